// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Three external pins (two general interrupt lines and a counter input) each pass through a synchronizer and an edge detector whose active edge is programmable. A key-wake port raises a request when the AND of its lines falls. Seven single-cycle pulses arrive from internal peripherals: serial receive and transmit, three timers, a second serial unit and the converter. Every maskable source has its own request latch and enable bit. Hardware events set the latches. Software may only clear them.

The eleven maskable sources share seven vector slots. Four of the slots are each shared by two sources, and the upper nibble of a select register picks which source drives each of those slots. A reset-pending slot sits above all of them, and a software-break slot sits below all of them. Neither of these two can be masked. The winning slot gives a 16-bit vector address. The processor asks for a decision with a sample strobe and later completes the handshake with an acknowledge.

The vector side follows valid/ready rules. `vec_valid_o` rises together with the one-cycle `take_o` pulse. While it is high, `vec_o` holds still, and new requests, even ones of higher priority, cannot replace it. `ack_i` acts as ready. The transfer completes on the cycle where both are high. An `ack_i` while nothing is valid is ignored.

Top module: `prio_vec_irq`

## Requirements
- R1: After reset, `req_o`=0, `en_o`=0, `idis_o`=1 and `vec_valid_o`=0. The reset slot is pending, so the first sample gives vector FFFC even though the disable flag is set.
- R2: An internal pulse sets its request latch at the next clock edge. Request bit order: 0 serial-rx, 1 serial-tx, 2 INT1, 3 INT0, 4 timer X, 5 key-wake, 6 timer 1, 7 timer 2, 8 serial-2, 9 counter input, 10 converter. `evt_i` bit order: 0 serial-rx, 1 serial-tx, 2 timer X, 3 timer 1, 4 timer 2, 5 serial-2, 6 converter. A clear strobe clears the latches whose mask bit is 1 and never sets any latch. If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R3: A maskable slot can win only when its routed source has request=1 and enable=1 and the disable flag is 0.
- R4: Priority order and vectors, highest first: reset FFFC, serial-rx FFFA, serial-tx/INT1 FFF8, INT0 FFF6, timer X/key-wake FFF4, timer 1 FFF2, timer 2/serial-2 FFF0, counter/converter FFEE, break FFEC.
- R5: Select bits 4, 5, 6 and 7 pick the second source of the FFF8, FFF4, FFF0 and FFEE slots respectively when set to 1 (INT1, key-wake, serial-2, converter). A source that is not routed to its slot cannot win.
- R6: A `brk_i` pulse is latched and wins at FFEC whatever the enables and the disable flag are.
- R7: A sample with a candidate present and nothing in service gives `take_o` for exactly one cycle on the next edge. `vec_valid_o` then stays high and `vec_o` stays stable until `ack_i`.
- R8: An acknowledge clears the request latch of the serviced source, sets `idis_o` and drops `vec_valid_o`.
- R9: INT0, INT1 and the counter input go through a two-stage synchronizer. Select bits 0, 1 and 2 choose the active edge for each of them (0 rising, 1 falling). A matching edge sets the request latch within three clock edges.
- R10: A falling edge of the AND of all key-port lines sets the key-wake request. A rising edge does not.
- R11: Changing a polarity bit while the pin is steady can set that source's request latch.
- R12: Enable bits are written as a whole word and read back on `en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_int0_i | input | 1 | External interrupt line 0 (asynchronous) |
| ext_int1_i | input | 1 | External interrupt line 1 (asynchronous) |
| ext_cntr_i | input | 1 | Counter input pin (asynchronous) |
| key_port_i | input | KEYW | Key-wake port lines |
| evt_i | input | 7 | Internal completion pulses, order per R2 |
| brk_i | input | 1 | Software break strobe |
| en_wr_i | input | 1 | Enable-word write strobe |
| en_wdata_i | input | 11 | Enable word |
| clr_wr_i | input | 1 | Request-clear strobe |
| clr_mask_i | input | 11 | Bits to clear |
| esel_wr_i | input | 1 | Select register write strobe |
| esel_wdata_i | input | 8 | Polarity in bits 2:0, slot select in bits 7:4 |
| idis_wr_i | input | 1 | Disable-flag write strobe |
| idis_wdata_i | input | 1 | Disable-flag value |
| sample_i | input | 1 | Processor interrupt-sample strobe |
| ack_i | input | 1 | Vector consumed (ready) |
| take_o | output | 1 | One-cycle accept pulse |
| vec_valid_o | output | 1 | Vector held for the processor |
| vec_o | output | 16 | Low-byte vector address |
| idis_o | output | 1 | Interrupt-disable flag |
| req_o | output | 11 | Request latches |
| en_o | output | 11 | Enable bits |

## Verification
The hardest case to reach is the spurious request that comes from rewriting a polarity bit while the pin stays still. Setting it up takes an empty latch, a quiet synchronizer, and a select write that flips only the edge choice. The bench holds INT0 low for several cycles and clears its latch. It then writes a falling-edge polarity and checks `req_o` before the pin moves again. A second hard case is a higher-priority event that arrives while a vector is held. The bench triggers serial-rx during a timer-1 service and checks that the held vector does not change and that the new request wins the next sample.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC  = 11;
  localparam int NSLOT = 9;
  localparam int SW    = 4;
  localparam int NEVT  = 7;

  localparam logic [SW-1:0] SRC_S1RX = 4'd0;
  localparam logic [SW-1:0] SRC_S1TX = 4'd1;
  localparam logic [SW-1:0] SRC_INT1 = 4'd2;
  localparam logic [SW-1:0] SRC_INT0 = 4'd3;
  localparam logic [SW-1:0] SRC_TIMX = 4'd4;
  localparam logic [SW-1:0] SRC_KEY  = 4'd5;
  localparam logic [SW-1:0] SRC_TIM1 = 4'd6;
  localparam logic [SW-1:0] SRC_TIM2 = 4'd7;
  localparam logic [SW-1:0] SRC_SIO2 = 4'd8;
  localparam logic [SW-1:0] SRC_CNTR = 4'd9;
  localparam logic [SW-1:0] SRC_ADC  = 4'd10;

  localparam logic [SW-1:0] SLOT_RST = 4'd0;
  localparam logic [SW-1:0] SLOT_BRK = 4'd8;

  // Source routed to a maskable slot, given the four select bits.
  function automatic logic [SW-1:0] slot_src(input int slot, input logic [3:0] sel);
    case (slot)
      1:       return SRC_S1RX;
      2:       return sel[0] ? SRC_INT1 : SRC_S1TX;
      3:       return SRC_INT0;
      4:       return sel[1] ? SRC_KEY : SRC_TIMX;
      5:       return SRC_TIM1;
      6:       return sel[2] ? SRC_SIO2 : SRC_TIM2;
      7:       return sel[3] ? SRC_ADC : SRC_CNTR;
      default: return SRC_S1RX;
    endcase
  endfunction
endpackage

// File: rtl/vic_edge_in.sv
module vic_edge_in #(
  parameter int NSYNC = 2,
  parameter int NCH   = 3,
  parameter int KEYW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pin_i,
  input  logic [NCH-1:0]  pol_i,
  input  logic [KEYW-1:0] key_i,
  output logic [NCH-1:0]  pin_evt_o,
  output logic            key_evt_o
);
  logic [NSYNC-1:0][NCH-1:0]  pin_sh;
  logic [NSYNC-1:0][KEYW-1:0] key_sh;
  logic [NCH-1:0] lvl, lvl_q;
  logic key_and, key_and_q;

  // Polarity folded in before the edge register: a toggle can look like an edge (R11)
  assign lvl     = pin_sh[NSYNC-1] ^ pol_i;
  assign key_and = &key_sh[NSYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh    <= '0;
      key_sh    <= '1;
      lvl_q     <= '0;
      key_and_q <= 1'b1;
    end else begin
      pin_sh    <= {pin_sh[NSYNC-2:0], pin_i};
      key_sh    <= {key_sh[NSYNC-2:0], key_i};
      lvl_q     <= lvl;
      key_and_q <= key_and;
    end
  end

  assign pin_evt_o = lvl & ~lvl_q;
  assign key_evt_o = key_and_q & ~key_and;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_evt_o[c] |=> !pin_evt_o[c]);
  end
  p_key_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt_o |=> !key_evt_o);
endmodule

// File: rtl/vic_req_bank.sv
module vic_req_bank
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_mask_i,
  input  logic [NSRC-1:0] ack_clr_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  output logic [NSRC-1:0] req_o,
  output logic [NSRC-1:0] en_o
);
  logic [NSRC-1:0] req_q, req_d, en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // A hardware event beats any clear in the same cycle (R2)
    assign req_d[i] = set_i[i] |
                      (req_q[i] & ~(clr_wr_i & clr_mask_i[i]) & ~ack_clr_i[i]);

    p_req_hw_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q[i]) |-> $past(set_i[i]));
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> req_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= req_d;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign req_o = req_q;
  assign en_o  = en_q;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pend_i,
  input  logic            brk_pend_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [3:0]      sel_i,
  input  logic            idis_i,
  output logic            any_o,
  output logic [SW-1:0]   slot_o,
  output logic [SW-1:0]   src_o,
  output logic [15:0]     vec_o
);
  logic [NSLOT-1:0] cand;

  assign cand[0]       = rst_pend_i;
  assign cand[NSLOT-1] = brk_pend_i;
  for (genvar k = 1; k < NSLOT-1; k++) begin : g_slot
    assign cand[k] = ~idis_i & req_i[slot_src(k, sel_i)] & en_i[slot_src(k, sel_i)];
  end

  // Lowest slot number wins
  always_comb begin
    any_o  = 1'b0;
    slot_o = '0;
    for (int k = NSLOT-1; k >= 0; k--) begin
      if (cand[k]) begin
        any_o  = 1'b1;
        slot_o = SW'(k);
      end
    end
  end

  assign src_o = slot_src(int'(slot_o), sel_i);
  assign vec_o = VEC_TOP - {11'd0, slot_o, 1'b0};

  p_win_is_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> cand[slot_o]);
  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_o && slot_o != SLOT_RST && slot_o != SLOT_BRK) |-> !idis_i);
endmodule

// File: rtl/prio_vec_irq.sv
module prio_vec_irq
  import vic_pkg::*;
#(
  parameter int          KEYW    = 4,
  parameter int          NSYNC   = 2,
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_int0_i,
  input  logic              ext_int1_i,
  input  logic              ext_cntr_i,
  input  logic [KEYW-1:0]   key_port_i,
  input  logic [NEVT-1:0]   evt_i,
  input  logic              brk_i,
  input  logic              en_wr_i,
  input  logic [NSRC-1:0]   en_wdata_i,
  input  logic              clr_wr_i,
  input  logic [NSRC-1:0]   clr_mask_i,
  input  logic              esel_wr_i,
  input  logic [7:0]        esel_wdata_i,
  input  logic              idis_wr_i,
  input  logic              idis_wdata_i,
  input  logic              sample_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic              vec_valid_o,
  output logic [15:0]       vec_o,
  output logic              idis_o,
  output logic [NSRC-1:0]   req_o,
  output logic [NSRC-1:0]   en_o
);
  localparam int NCH = 3;

  logic [2:0]      pol_q;
  logic [3:0]      sel_q;
  logic            esel_unused;
  logic [NCH-1:0]  pin_evt;
  logic            key_evt;
  logic [NSRC-1:0] set_vec, ack_clr, req_w, en_w;
  logic            rst_pend_q, brk_pend_q, idis_q;
  logic            busy_q, take_q;
  logic [15:0]     vec_q;
  logic [SW-1:0]   slot_q, src_q;
  logic            arb_any;
  logic [SW-1:0]   arb_slot, arb_src;
  logic [15:0]     arb_vec;
  logic            accept, do_ack;

  assign esel_unused = esel_wdata_i[3];

  vic_edge_in #(.NSYNC(NSYNC), .NCH(NCH), .KEYW(KEYW)) u_edge (
    .clk, .rst_n,
    .pin_i     ({ext_cntr_i, ext_int1_i, ext_int0_i}),
    .pol_i     (pol_q),
    .key_i     (key_port_i),
    .pin_evt_o (pin_evt),
    .key_evt_o (key_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_S1RX] = evt_i[0];
    set_vec[SRC_S1TX] = evt_i[1];
    set_vec[SRC_INT1] = pin_evt[1];
    set_vec[SRC_INT0] = pin_evt[0];
    set_vec[SRC_TIMX] = evt_i[2];
    set_vec[SRC_KEY]  = key_evt;
    set_vec[SRC_TIM1] = evt_i[3];
    set_vec[SRC_TIM2] = evt_i[4];
    set_vec[SRC_SIO2] = evt_i[5];
    set_vec[SRC_CNTR] = pin_evt[2];
    set_vec[SRC_ADC]  = evt_i[6];
  end

  assign do_ack  = ack_i & busy_q;
  assign accept  = sample_i & arb_any & ~busy_q;
  assign ack_clr = (do_ack && slot_q != SLOT_RST && slot_q != SLOT_BRK)
                   ? (NSRC'(1) << src_q) : '0;

  vic_req_bank u_bank (
    .clk, .rst_n,
    .set_i      (set_vec),
    .clr_wr_i   (clr_wr_i),
    .clr_mask_i (clr_mask_i),
    .ack_clr_i  (ack_clr),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .req_o      (req_w),
    .en_o       (en_w)
  );

  vic_arbiter #(.VEC_TOP(VEC_TOP)) u_arb (
    .clk, .rst_n,
    .rst_pend_i (rst_pend_q),
    .brk_pend_i (brk_pend_q),
    .req_i      (req_w),
    .en_i       (en_w),
    .sel_i      (sel_q),
    .idis_i     (idis_q),
    .any_o      (arb_any),
    .slot_o     (arb_slot),
    .src_o      (arb_src),
    .vec_o      (arb_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q      <= '0;
      sel_q      <= '0;
      rst_pend_q <= 1'b1;
      brk_pend_q <= 1'b0;
      idis_q     <= 1'b1;
      busy_q     <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
      slot_q     <= '0;
      src_q      <= '0;
    end else begin
      if (esel_wr_i) begin
        pol_q <= esel_wdata_i[2:0];
        sel_q <= esel_wdata_i[7:4];
      end
      if (do_ack && slot_q == SLOT_RST) rst_pend_q <= 1'b0;
      if (brk_i) brk_pend_q <= 1'b1;
      else if (do_ack && slot_q == SLOT_BRK) brk_pend_q <= 1'b0;
      if (do_ack) idis_q <= 1'b1;
      else if (idis_wr_i) idis_q <= idis_wdata_i;
      take_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        vec_q  <= arb_vec;
        slot_q <= arb_slot;
        src_q  <= arb_src;
      end else if (do_ack) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign take_o      = take_q;
  assign vec_valid_o = busy_q;
  assign vec_o       = vec_q;
  assign idis_o      = idis_q;
  assign req_o       = req_w;
  assign en_o        = en_w;

  p_take_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  p_take_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vec_valid_o);
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !ack_i) |=> (vec_valid_o && $stable(vec_o)));
  p_ack_idis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && ack_i) |=> (idis_o && !vec_valid_o));
endmodule

// File: tb/tb_prio_vec_irq.sv
module tb_prio_vec_irq;
  localparam int CLK_PERIOD = 10;
  localparam int KEYW = 4;

  typedef struct packed {
    logic [6:0]  evt;
    logic [10:0] en;
    logic [3:0]  sel;
    logic        idis;
    logic        take;
    logic [15:0] vec;
  } row_t;

  // Table rows exercise R3, R4, R5
  localparam row_t TBL [11] = '{
    '{7'h01, 11'h7FF, 4'h0, 1'b0, 1'b1, 16'hFFFA},
    '{7'h42, 11'h7FF, 4'h0, 1'b0, 1'b1, 16'hFFF8},
    '{7'h40, 11'h7FF, 4'h0, 1'b0, 1'b0, 16'h0000},
    '{7'h40, 11'h7FF, 4'h8, 1'b0, 1'b1, 16'hFFEE},
    '{7'h18, 11'h7FF, 4'h0, 1'b0, 1'b1, 16'hFFF2},
    '{7'h10, 11'h77F, 4'h0, 1'b0, 1'b0, 16'h0000},
    '{7'h04, 11'h7FF, 4'h0, 1'b1, 1'b0, 16'h0000},
    '{7'h20, 11'h7FF, 4'h4, 1'b0, 1'b1, 16'hFFF0},
    '{7'h24, 11'h7FF, 4'h0, 1'b0, 1'b1, 16'hFFF4},
    '{7'h02, 11'h7FF, 4'h1, 1'b0, 1'b0, 16'h0000},
    '{7'h04, 11'h7FF, 4'h2, 1'b0, 1'b0, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic ext_int0 = 0, ext_int1 = 0, ext_cntr = 0;
  logic [KEYW-1:0] key_port = '1;
  logic [6:0] evt = '0;
  logic brk = 0, en_wr = 0, clr_wr = 0, esel_wr = 0, idis_wr = 0, idis_wd = 0;
  logic sample = 0, ack = 0;
  logic [10:0] en_wd = '0, clr_mask = '0;
  logic [7:0] esel_wd = '0;
  logic take, vvalid, idis;
  logic [15:0] vec;
  logic [10:0] req, en;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_irq #(.KEYW(KEYW)) dut (
    .clk, .rst_n,
    .ext_int0_i(ext_int0), .ext_int1_i(ext_int1), .ext_cntr_i(ext_cntr),
    .key_port_i(key_port), .evt_i(evt), .brk_i(brk),
    .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask),
    .esel_wr_i(esel_wr), .esel_wdata_i(esel_wd),
    .idis_wr_i(idis_wr), .idis_wdata_i(idis_wd),
    .sample_i(sample), .ack_i(ack),
    .take_o(take), .vec_valid_o(vvalid), .vec_o(vec), .idis_o(idis),
    .req_o(req), .en_o(en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [10:0] v);
    @(negedge clk); en_wr = 1; en_wd = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic clr(input logic [10:0] m);
    @(negedge clk); clr_wr = 1; clr_mask = m;
    @(negedge clk); clr_wr = 0; clr_mask = '0;
  endtask

  task automatic wr_esel(input logic [7:0] v);
    @(negedge clk); esel_wr = 1; esel_wd = v;
    @(negedge clk); esel_wr = 0;
  endtask

  task automatic wr_idis(input logic v);
    @(negedge clk); idis_wr = 1; idis_wd = v;
    @(negedge clk); idis_wr = 0;
  endtask

  task automatic pulse_evt(input logic [6:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic do_sample;
    @(negedge clk); sample = 1;
    @(negedge clk); sample = 0;
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 req", 32'(req), 0);
    chk("R1 en", 32'(en), 0);
    chk("R1 idis", 32'(idis), 1);
    chk("R1 valid", 32'(vvalid), 0);
    do_sample;
    chk("R1 take", 32'(take), 1);
    chk("R1 reset vec", 32'(vec), 32'hFFFC);
    do_ack;
    chk("R1 valid after ack", 32'(vvalid), 0);

    // Vector table: R3 R4 R5
    foreach (TBL[i]) begin
      clr(11'h7FF);
      wr_en(TBL[i].en);
      wr_esel({TBL[i].sel, 4'h0});
      wr_idis(TBL[i].idis);
      pulse_evt(TBL[i].evt);
      do_sample;
      chk($sformatf("R3 R4 R5 row%0d take", i), 32'(take), 32'(TBL[i].take));
      if (TBL[i].take) begin
        chk($sformatf("R4 R5 row%0d vec", i), 32'(vec), 32'(TBL[i].vec));
        do_ack;
      end else begin
        chk($sformatf("R3 R5 row%0d valid", i), 32'(vvalid), 0);
      end
    end
    clr(11'h7FF);
    wr_esel(8'h00);

    // R12 enable readback
    wr_en(11'h2A5);
    chk("R12 en readback", 32'(en), 32'h2A5);

    // R2 set, clear, clear-can't-set, same-cycle race
    wr_en(11'h000);
    pulse_evt(7'h08);
    chk("R2 event sets tim1", 32'(req), 32'h040);
    clr(11'h040);
    chk("R2 clear", 32'(req), 0);
    clr(11'h7FF);
    chk("R2 clear never sets", 32'(req), 0);
    pulse_evt(7'h08);
    @(negedge clk); evt = 7'h08; clr_wr = 1; clr_mask = 11'h040;
    @(negedge clk); evt = '0; clr_wr = 0; clr_mask = '0;
    chk("R2 event beats clear", 32'(req[6]), 1);
    clr(11'h7FF);

    // R6 break ignores masking
    wr_idis(1'b1);
    @(negedge clk); brk = 1;
    @(negedge clk); brk = 0;
    do_sample;
    chk("R6 brk take", 32'(take), 1);
    chk("R6 brk vec", 32'(vec), 32'hFFEC);
    do_ack;

    // R7 vector held while higher source arrives, R8 ack effects
    wr_en(11'h7FF);
    wr_idis(1'b0);
    pulse_evt(7'h08);
    do_sample;
    chk("R7 take", 32'(take), 1);
    chk("R7 vec tim1", 32'(vec), 32'hFFF2);
    idle(1);
    chk("R7 take one cycle", 32'(take), 0);
    pulse_evt(7'h01);
    idle(2);
    chk("R7 vec held", 32'(vec), 32'hFFF2);
    chk("R7 valid held", 32'(vvalid), 1);
    do_ack;
    chk("R8 req cleared", 32'(req), 32'h001);
    chk("R8 idis set", 32'(idis), 1);
    chk("R8 valid drop", 32'(vvalid), 0);
    wr_idis(1'b0);
    do_sample;
    chk("R7 next winner", 32'(vec), 32'hFFFA);
    do_ack;
    clr(11'h7FF);

    // R9 edges through synchronizer, R11 polarity toggle
    @(negedge clk); ext_int0 = 1;
    idle(4);
    chk("R9 int0 rising", 32'(req[3]), 1);
    clr(11'h7FF);
    @(negedge clk); ext_int0 = 0;
    idle(4);
    chk("R9 falling ignored in rising mode", 32'(req[3]), 0);
    wr_esel(8'h01);
    idle(2);
    chk("R11 polarity toggle raises int0", 32'(req[3]), 1);
    clr(11'h7FF);
    @(negedge clk); ext_int0 = 1;
    idle(4);
    chk("R9 rising ignored in falling mode", 32'(req[3]), 0);
    @(negedge clk); ext_int0 = 0;
    idle(4);
    chk("R9 int0 falling", 32'(req[3]), 1);
    wr_esel(8'h00);
    clr(11'h7FF);
    @(negedge clk); ext_int1 = 1; ext_cntr = 1;
    idle(4);
    chk("R9 int1 and cntr", 32'(req), 32'h204);
    @(negedge clk); ext_int1 = 0; ext_cntr = 0;
    idle(4);
    clr(11'h7FF);

    // R10 key wake on falling AND
    @(negedge clk); key_port[1] = 0;
    idle(4);
    chk("R10 key falling", 32'(req[5]), 1);
    clr(11'h7FF);
    @(negedge clk); key_port[1] = 1;
    idle(4);
    chk("R10 key rising ignored", 32'(req[5]), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule